// File: doc/BRIEF.md
# Operand Bypass Select Unit

This block sits beside the execute and memory stages of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It decides, every cycle and without any storage of its own, where the two ALU operands of the instruction now in execute should come from. There are three possible sources: the value read from the register file during decode, the ALU result held in the execute/memory pipeline register, or the value held in the memory/writeback pipeline register. It also decides whether a store now in the memory stage takes its write data from its own pipeline register or from the load that has just moved into writeback. That last path lets a load followed directly by a store of the same register run with no bubble.

The inputs are the consumer's register numbers and, for each of the two older instructions, a destination register number, a register-write flag and a load flag. The outputs are mux select codes that drive the operand and store-data multiplexers elsewhere in the datapath. The block does not compute values and does not stall. When a load in the memory stage feeds the execute stage, the separate stall logic must hold the consumer. This unit only refuses to forward the not-yet-valid value in that case.

Top module: `fwd_unit`

## Requirements
- R1: An ALU operand whose register equals the destination of a register-writing, non-load instruction in the execute/memory register gets select code 2'b10.
- R2: An ALU operand whose register equals the destination of a register-writing instruction in the memory/writeback register (load or not) gets select code 2'b01, provided R1 and R6 do not apply.
- R3: When both older instructions match the same operand, the execute/memory one wins and the code is 2'b10.
- R4: A producer whose register-write flag is low never causes a match, whatever its destination.
- R5: Register 0 is never forwarded: a destination of 0 matches nothing, and an operand of register 0 always gets 2'b00.
- R6: If the matching instruction in execute/memory is a load, the operand gets 2'b00 even when the memory/writeback instruction also matches.
- R7: An operand with no valid match gets 2'b00, the register file value.
- R8: The store-data select is 1 when the memory-stage instruction is a store, the writeback-stage instruction is a register-writing load, its destination is not 0, and it equals the store's data register.
- R9: The store-data select is 0 when the writeback-stage producer is not a load, when the memory-stage instruction is not a store, or when the registers differ.
- R10: The two operand selects are computed independently, so one operand may take 2'b10 while the other takes 2'b01 in the same cycle.
- R11: The outputs are purely combinational in the current inputs and hold no state between cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_i | input | REG_AW | First source register of the instruction in execute |
| ex_rt_i | input | REG_AW | Second source register of the instruction in execute |
| exm_rd_i | input | REG_AW | Destination register held in the execute/memory register |
| exm_wr_i | input | 1 | Register-write flag of the execute/memory instruction |
| exm_load_i | input | 1 | The execute/memory instruction is a load |
| exm_store_i | input | 1 | The execute/memory instruction is a store |
| exm_rt_i | input | REG_AW | Data register of the store in execute/memory |
| mwb_rd_i | input | REG_AW | Destination register held in the memory/writeback register |
| mwb_wr_i | input | 1 | Register-write flag of the memory/writeback instruction |
| mwb_load_i | input | 1 | The memory/writeback instruction is a load |
| alu_a_sel_o | output | 2 | Source code for the first ALU operand |
| alu_b_sel_o | output | 2 | Source code for the second ALU operand |
| st_data_sel_o | output | 1 | 1 selects the memory/writeback value as store data |

## Verification
The bench targets the double match, where a design that favours the older result would feed a stale value to the ALU, and the load sitting in execute/memory, where a design that forwards it would hand over an address instead of data, and one that falls through to writeback would pass an outdated copy. It drives register 0 as both destination and operand, and clears the write flags with matching numbers, since a careless compare there would corrupt reads of the hard-wired zero or forward from branches and stores. For the memory-to-memory path it varies the load flag, the store flag and the register equality one at a time, so a design that ignored any one of them would show up.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_MEMWB   = 2'b01,
        SRC_EXMEM   = 2'b10
    } src_sel_e;

endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] want_i,
    input  logic [REG_AW-1:0] dest_i,
    input  logic              wr_i,
    output logic              hit_o
);
    // A producer counts only if it writes a real (non-zero) register.
    always_comb begin
        hit_o = wr_i && (dest_i != '0) && (dest_i == want_i);
    end
endmodule

// File: rtl/fwd_oper_sel.sv
module fwd_oper_sel
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_i,
    input  logic [REG_AW-1:0] exm_rd_i,
    input  logic              exm_wr_i,
    input  logic              exm_load_i,
    input  logic [REG_AW-1:0] mwb_rd_i,
    input  logic              mwb_wr_i,
    output src_sel_e          sel_o
);
    logic exm_hit;
    logic mwb_hit;

    fwd_hit #(.REG_AW(REG_AW)) u_hit_exm (
        .want_i (src_i),
        .dest_i (exm_rd_i),
        .wr_i   (exm_wr_i),
        .hit_o  (exm_hit)
    );

    fwd_hit #(.REG_AW(REG_AW)) u_hit_mwb (
        .want_i (src_i),
        .dest_i (mwb_rd_i),
        .wr_i   (mwb_wr_i),
        .hit_o  (mwb_hit)
    );

    // Younger producer first; a load in EX/MEM has no data yet and
    // also shadows any older copy in MEM/WB.
    always_comb begin
        unique case ({exm_hit, mwb_hit})
            2'b10, 2'b11: sel_o = exm_load_i ? SRC_REGFILE : SRC_EXMEM;
            2'b01:        sel_o = SRC_MEMWB;
            default:      sel_o = SRC_REGFILE;
        endcase
    end
endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel #(
    parameter int REG_AW = 5
) (
    input  logic              exm_store_i,
    input  logic [REG_AW-1:0] exm_rt_i,
    input  logic [REG_AW-1:0] mwb_rd_i,
    input  logic              mwb_wr_i,
    input  logic              mwb_load_i,
    output logic              sel_o
);
    logic load_wr;
    logic hit;

    always_comb begin
        load_wr = mwb_wr_i && mwb_load_i;
    end

    fwd_hit #(.REG_AW(REG_AW)) u_hit_st (
        .want_i (exm_rt_i),
        .dest_i (mwb_rd_i),
        .wr_i   (load_wr),
        .hit_o  (hit)
    );

    always_comb begin
        sel_o = exm_store_i && hit;
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] ex_rs_i,
    input  logic [REG_AW-1:0] ex_rt_i,
    input  logic [REG_AW-1:0] exm_rd_i,
    input  logic              exm_wr_i,
    input  logic              exm_load_i,
    input  logic              exm_store_i,
    input  logic [REG_AW-1:0] exm_rt_i,
    input  logic [REG_AW-1:0] mwb_rd_i,
    input  logic              mwb_wr_i,
    input  logic              mwb_load_i,
    output logic [1:0]        alu_a_sel_o,
    output logic [1:0]        alu_b_sel_o,
    output logic              st_data_sel_o
);
    localparam int N_OPS = 2;

    logic [REG_AW-1:0] op_src [N_OPS];
    src_sel_e          op_sel [N_OPS];

    always_comb begin
        op_src[0] = ex_rs_i;
        op_src[1] = ex_rt_i;
    end

    for (genvar g = 0; g < N_OPS; g++) begin : g_oper
        fwd_oper_sel #(.REG_AW(REG_AW)) u_sel (
            .src_i      (op_src[g]),
            .exm_rd_i   (exm_rd_i),
            .exm_wr_i   (exm_wr_i),
            .exm_load_i (exm_load_i),
            .mwb_rd_i   (mwb_rd_i),
            .mwb_wr_i   (mwb_wr_i),
            .sel_o      (op_sel[g])
        );
    end

    always_comb begin
        alu_a_sel_o = op_sel[0];
        alu_b_sel_o = op_sel[1];
    end

    fwd_store_sel #(.REG_AW(REG_AW)) u_store (
        .exm_store_i (exm_store_i),
        .exm_rt_i    (exm_rt_i),
        .mwb_rd_i    (mwb_rd_i),
        .mwb_wr_i    (mwb_wr_i),
        .mwb_load_i  (mwb_load_i),
        .sel_o       (st_data_sel_o)
    );
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int REG_AW = 5
) (
    input logic [REG_AW-1:0] ex_rs_i,
    input logic [REG_AW-1:0] ex_rt_i,
    input logic [REG_AW-1:0] exm_rd_i,
    input logic              exm_wr_i,
    input logic              exm_load_i,
    input logic              exm_store_i,
    input logic [REG_AW-1:0] exm_rt_i,
    input logic [REG_AW-1:0] mwb_rd_i,
    input logic              mwb_wr_i,
    input logic              mwb_load_i,
    input logic [1:0]        alu_a_sel_o,
    input logic [1:0]        alu_b_sel_o,
    input logic              st_data_sel_o
);
    always_comb begin
        if (exm_wr_i && !exm_load_i && exm_rd_i != '0 && exm_rd_i == ex_rs_i)
            AST_EXM_WINS_A: assert (alu_a_sel_o == 2'b10); // R3
        if (ex_rt_i == '0)
            AST_ZERO_B: assert (alu_b_sel_o == 2'b00); // R5
        if (exm_wr_i && exm_load_i && exm_rd_i != '0 && exm_rd_i == ex_rs_i)
            AST_LOAD_HOLD_A: assert (alu_a_sel_o == 2'b00); // R6
        if (!exm_wr_i && !mwb_wr_i)
            AST_NO_WRITERS: assert (alu_a_sel_o == 2'b00 && alu_b_sel_o == 2'b00); // R4
        if (!mwb_load_i || !exm_store_i)
            AST_ST_NEEDS_PAIR: assert (!st_data_sel_o); // R9
        if (st_data_sel_o)
            AST_ST_MATCH: assert (mwb_rd_i == exm_rt_i && mwb_rd_i != '0); // R8
    end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_AW(REG_AW)) u_chk (.*);

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
    localparam int AW = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [AW-1:0] ex_rs, ex_rt, exm_rd, exm_rt, mwb_rd;
    logic exm_wr, exm_load, exm_store, mwb_wr, mwb_load;
    logic [1:0] a_sel, b_sel;
    logic st_sel;

    int n_chk = 0;
    int n_bad = 0;

    fwd_unit #(.REG_AW(AW)) u_dut (
        .ex_rs_i(ex_rs), .ex_rt_i(ex_rt),
        .exm_rd_i(exm_rd), .exm_wr_i(exm_wr), .exm_load_i(exm_load),
        .exm_store_i(exm_store), .exm_rt_i(exm_rt),
        .mwb_rd_i(mwb_rd), .mwb_wr_i(mwb_wr), .mwb_load_i(mwb_load),
        .alu_a_sel_o(a_sel), .alu_b_sel_o(b_sel), .st_data_sel_o(st_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        ex_rs = 5'd1; ex_rt = 5'd2; exm_rd = 5'd3; exm_rt = 5'd4; mwb_rd = 5'd5;
        exm_wr = 0; exm_load = 0; exm_store = 0; mwb_wr = 0; mwb_load = 0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        idle(); settle();
        chk("R7 a idle", a_sel, 0);
        chk("R7 b idle", b_sel, 0);
        chk("R9 st idle", st_sel, 0);
    endtask

    task automatic t_exm_path();
        idle(); exm_wr = 1; exm_rd = 5'd7; ex_rs = 5'd7; settle();
        chk("R1 a from exmem", a_sel, 2);
        chk("R7 b untouched", b_sel, 0);
    endtask

    task automatic t_mwb_path();
        idle(); mwb_wr = 1; mwb_rd = 5'd9; ex_rt = 5'd9; settle();
        chk("R2 b from memwb", b_sel, 1);
        mwb_load = 1; settle();
        chk("R2 b from memwb load", b_sel, 1);
    endtask

    task automatic t_priority();
        idle(); exm_wr = 1; mwb_wr = 1; exm_rd = 5'd12; mwb_rd = 5'd12;
        ex_rs = 5'd12; ex_rt = 5'd12; settle();
        chk("R3 a younger wins", a_sel, 2);
        chk("R3 b younger wins", b_sel, 2);
    endtask

    task automatic t_no_write();
        idle(); exm_rd = 5'd6; mwb_rd = 5'd6; ex_rs = 5'd6; ex_rt = 5'd6;
        mwb_load = 1; exm_store = 1; exm_rt = 5'd6; settle();
        chk("R4 a no wr", a_sel, 0);
        chk("R4 b no wr", b_sel, 0);
        chk("R4 st no wr", st_sel, 0);
    endtask

    task automatic t_zero_reg();
        idle(); exm_wr = 1; mwb_wr = 1; exm_rd = 0; mwb_rd = 0; ex_rs = 0; ex_rt = 0;
        settle();
        chk("R5 a r0", a_sel, 0);
        chk("R5 b r0", b_sel, 0);
        mwb_load = 1; exm_store = 1; exm_rt = 0; settle();
        chk("R5 st r0", st_sel, 0);
    endtask

    task automatic t_load_in_exm();
        idle(); exm_wr = 1; exm_load = 1; exm_rd = 5'd8; ex_rs = 5'd8; settle();
        chk("R6 a load exmem", a_sel, 0);
        mwb_wr = 1; mwb_rd = 5'd8; settle();
        chk("R6 a load shadows memwb", a_sel, 0);
    endtask

    task automatic t_mixed();
        idle(); exm_wr = 1; exm_rd = 5'd10; mwb_wr = 1; mwb_rd = 5'd11;
        ex_rs = 5'd11; ex_rt = 5'd10; settle();
        chk("R10 a memwb", a_sel, 1);
        chk("R10 b exmem", b_sel, 2);
    endtask

    task automatic t_store_path();
        idle(); exm_store = 1; exm_rt = 5'd14; mwb_wr = 1; mwb_load = 1; mwb_rd = 5'd14;
        settle();
        chk("R8 st mem-mem", st_sel, 1);
        mwb_load = 0; settle();
        chk("R9 st non-load", st_sel, 0);
        mwb_load = 1; exm_store = 0; settle();
        chk("R9 st no store", st_sel, 0);
        exm_store = 1; exm_rt = 5'd15; settle();
        chk("R9 st mismatch", st_sel, 0);
    endtask

    task automatic t_comb();
        idle(); exm_wr = 1; exm_rd = 5'd3; ex_rs = 5'd3; #1;
        chk("R11 a same step", a_sel, 2);
        ex_rs = 5'd4; #1;
        chk("R11 a drops", a_sel, 0);
        settle();
    endtask

    initial begin
        idle();
        t_reset_state();
        t_exm_path();
        t_mwb_path();
        t_priority();
        t_no_write();
        t_zero_reg();
        t_load_in_exm();
        t_mixed();
        t_store_path();
        t_comb();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule